// File: doc/BRIEF.md
# Multi-core doorbell mailbox array

The block holds sixteen 32-bit doorbell registers. There are four cores, and each core owns four of them. Any bus agent can raise bits in a doorbell or lower them. A doorbell has no plain-write path. Bits are raised only by writing ones into the set window. Bits are lowered only by writing ones into the clear window. Both windows also read back the doorbell contents.

Each doorbell drives its own level interrupt line toward the interrupt router. The line stays high while any bit of that doorbell is one. Enabling and routing of these lines belong to the router. The meaning of each bit is up to software.

The register bus has `NUM_PORTS` independent agent ports (two by default), so several agents can reach the array in the same cycle. Each access is acknowledged one cycle after it is presented.

Top module: `doorbell_mbox`

## Requirements
- R1: After reset, all doorbells read zero, every interrupt line is low and no acknowledge is asserted.
- R2: A write to the set window at byte address 0x80 + 16*core + 4*slot ORs the written data into doorbell index core*4+slot. Address bits [1:0] are ignored, and no other doorbell changes.
- R3: A write to the clear window at byte address 0xC0 + 16*core + 4*slot clears every bit of that doorbell where the written data holds a one.
- R4: Bits where the write data is zero keep their value in both windows.
- R5: A read at a clear-window address returns the current contents of the addressed doorbell.
- R6: A read at a set-window address returns the same contents as the matching clear-window address.
- R7: Addresses below 0x80 are outside both windows. Writes there change no doorbell, and reads there return zero.
- R8: Interrupt line i (`mbox_irq[i]`, i = core*4+slot) is high exactly when doorbell i is nonzero. The line updates in the cycle after the clock edge that captures the write.
- R9: Every access on a port is acknowledged exactly one cycle after it is presented, and no acknowledge appears without an access. Read data comes with the acknowledge. A write returns zero data. A read captured in the same cycle as a write to the same doorbell returns the value from before the write.
- R10: If a set and a clear reach the same bit in the same cycle from different ports, the bit ends up set.
- R11: Writes to one doorbell from several ports in the same cycle all take effect. Set data from the ports is ORed together, and so is clear data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | NUM_PORTS | Access request, one bit per port |
| bus_wr | input | NUM_PORTS | 1 = write, 0 = read, one bit per port |
| bus_addr | input | NUM_PORTS*ADDR_W | Byte address, port p at bits [p*ADDR_W +: ADDR_W] |
| bus_wdata | input | NUM_PORTS*DATA_W | Write data, port p at bits [p*DATA_W +: DATA_W] |
| bus_ack | output | NUM_PORTS | Access acknowledge, one cycle after the request |
| bus_rdata | output | NUM_PORTS*DATA_W | Read data, valid while the acknowledge is high |
| mbox_irq | output | NUM_CORES*BOX_PER_CORE | Level interrupt per doorbell |

## Verification
The hardest case to reach is a set and a clear landing on the same bit in the same cycle. A single agent cannot produce it, because each agent issues one access per cycle. The stimulus drives both ports in one cycle: one port targets the set-window address of a doorbell and the other targets the clear-window address of the same doorbell, with overlapping masks. The same dual-port issue also covers three other cases: concurrent sets to one doorbell, concurrent clears to one doorbell, and a read racing a write to the same doorbell.

// File: rtl/doorbell_mbox.sv
module doorbell_mbox #(
  parameter int NUM_CORES    = 4,
  parameter int BOX_PER_CORE = 4,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 8,
  parameter int NUM_PORTS    = 2,
  parameter int SET_BASE     = 'h80,
  parameter int CLR_BASE     = 'hC0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PORTS-1:0]          bus_sel,
  input  logic [NUM_PORTS-1:0]          bus_wr,
  input  logic [NUM_PORTS*ADDR_W-1:0]   bus_addr,
  input  logic [NUM_PORTS*DATA_W-1:0]   bus_wdata,
  output logic [NUM_PORTS-1:0]          bus_ack,
  output logic [NUM_PORTS*DATA_W-1:0]   bus_rdata,
  output logic [NUM_CORES*BOX_PER_CORE-1:0] mbox_irq
);
  localparam int NUM_BOX   = NUM_CORES * BOX_PER_CORE;
  localparam int IDX_W     = $clog2(NUM_BOX);
  localparam int BYTES     = DATA_W / 8;
  localparam int OFS_W     = $clog2(BYTES);
  localparam int WIN_BYTES = NUM_BOX * BYTES;

  logic [DATA_W-1:0] mbox    [NUM_BOX];
  logic [DATA_W-1:0] set_m   [NUM_BOX];
  logic [DATA_W-1:0] clr_m   [NUM_BOX];
  logic [DATA_W-1:0] rdata_q [NUM_PORTS];
  logic [NUM_PORTS-1:0] hit_set, hit_clr;
  logic [IDX_W-1:0]     idx [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
    logic [31:0] a32;
    assign a32        = 32'(bus_addr[p*ADDR_W +: ADDR_W]);
    assign hit_set[p] = (a32 >= 32'(SET_BASE)) && (a32 < 32'(SET_BASE + WIN_BYTES));
    assign hit_clr[p] = (a32 >= 32'(CLR_BASE)) && (a32 < 32'(CLR_BASE + WIN_BYTES));
    assign idx[p]     = IDX_W'((a32 - (hit_clr[p] ? 32'(CLR_BASE) : 32'(SET_BASE))) >> OFS_W);
    assign bus_rdata[p*DATA_W +: DATA_W] = rdata_q[p];

    a_r9_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel[p] |=> bus_ack[p]);
    a_r9_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel[p] |=> !bus_ack[p]);
    a_r9_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel[p] && bus_wr[p]) |=> (bus_rdata[p*DATA_W +: DATA_W] == '0));
    a_r7_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel[p] && !bus_wr[p] && !hit_set[p] && !hit_clr[p])
        |=> (bus_rdata[p*DATA_W +: DATA_W] == '0));
  end

  always_comb begin
    for (int i = 0; i < NUM_BOX; i++) begin
      set_m[i] = '0;
      clr_m[i] = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (bus_sel[p] && bus_wr[p] && idx[p] == IDX_W'(i)) begin
          if (hit_set[p]) set_m[i] = set_m[i] | bus_wdata[p*DATA_W +: DATA_W];
          if (hit_clr[p]) clr_m[i] = clr_m[i] | bus_wdata[p*DATA_W +: DATA_W];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BOX; i++) mbox[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_BOX; i++) mbox[i] <= (mbox[i] & ~clr_m[i]) | set_m[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack <= '0;
      for (int p = 0; p < NUM_PORTS; p++) rdata_q[p] <= '0;
    end else begin
      bus_ack <= bus_sel;
      for (int p = 0; p < NUM_PORTS; p++)
        rdata_q[p] <= (bus_sel[p] && !bus_wr[p] && (hit_set[p] || hit_clr[p]))
                      ? mbox[idx[p]] : '0;
    end
  end

  for (genvar i = 0; i < NUM_BOX; i++) begin : g_box
    assign mbox_irq[i] = |mbox[i];

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_m[i] != '0) |=> ((mbox[i] & $past(set_m[i])) == $past(set_m[i])));
    a_r3_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_m[i] & ~set_m[i]) != '0) |=> ((mbox[i] & $past(clr_m[i] & ~set_m[i])) == '0));
    a_r4_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (set_m[i] == '0 && clr_m[i] == '0) |=> $stable(mbox[i]));
    a_r8_irq_on_set: assert property (@(posedge clk) disable iff (!rst_n)
      (set_m[i] != '0) |=> mbox_irq[i]);
  end
endmodule

// File: tb/tb_doorbell_mbox.sv
module tb_doorbell_mbox;
  localparam int NP = 2;
  localparam int NB = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [NP-1:0] sel, wr;
  logic [NP*8-1:0]  addr;
  logic [NP*32-1:0] wdata;
  wire  [NP-1:0]    ack;
  wire  [NP*32-1:0] rdata;
  wire  [NB-1:0]    irq;

  doorbell_mbox dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_ack(ack), .bus_rdata(rdata), .mbox_irq(irq)
  );

  typedef struct packed { logic [0:0] port; int due; logic [31:0] exp; } item_t;
  item_t       q[$];
  string       tq[$];
  logic [31:0] model [NB];
  int checks = 0, fails = 0, cyc = 0;

  always @(posedge clk) cyc = cyc + 1;

  function automatic void chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  function automatic int box_of(logic [7:0] a, output bit s, output bit c);
    s = (a >= 8'h80) && (a < 8'hC0);
    c = (a >= 8'hC0);
    return int'(a[5:2]);
  endfunction

  function automatic logic [NB-1:0] model_irq();
    logic [NB-1:0] v;
    for (int i = 0; i < NB; i++) v[i] = (model[i] != 32'h0);
    return v;
  endfunction

  task automatic issue(input bit e0, input bit w0, input logic [7:0] a0, input logic [31:0] d0,
                       input bit e1, input bit w1, input logic [7:0] a1, input logic [31:0] d1,
                       input string tag);
    bit en [NP];
    bit we [NP];
    logic [7:0]  ad [NP];
    logic [31:0] dd [NP];
    logic [31:0] setv [NB];
    logic [31:0] clrv [NB];
    @(negedge clk);
    sel = {e1, e0}; wr = {w1, w0}; addr = {a1, a0}; wdata = {d1, d0};
    en[0] = e0; en[1] = e1; we[0] = w0; we[1] = w1;
    ad[0] = a0; ad[1] = a1; dd[0] = d0; dd[1] = d1;
    for (int i = 0; i < NB; i++) begin setv[i] = 0; clrv[i] = 0; end
    for (int p = 0; p < NP; p++) begin
      if (en[p]) begin
        bit s, c;
        int b;
        item_t it;
        b = box_of(ad[p], s, c);
        it.port = 1'(p);
        it.due  = cyc + 1;
        it.exp  = (!we[p] && (s || c)) ? model[b] : 32'h0;
        q.push_back(it);
        tq.push_back(tag);
        if (we[p] && s) setv[b] = setv[b] | dd[p];
        if (we[p] && c) clrv[b] = clrv[b] | dd[p];
      end
    end
    for (int i = 0; i < NB; i++) model[i] = (model[i] & ~clrv[i]) | setv[i];
  endtask

  task automatic idle();
    @(negedge clk);
    sel = '0; wr = '0;
  endtask

  task automatic wr0(input logic [7:0] a, input logic [31:0] d, input string tag);
    issue(1, 1, a, d, 0, 0, 8'h0, 32'h0, tag);
  endtask

  task automatic rd0(input logic [7:0] a, input string tag);
    issue(1, 0, a, 32'h0, 0, 0, 8'h0, 32'h0, tag);
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < NB; i++) begin
      issue(1, 0, 8'(8'hC0 + 16 * (i / 4) + 4 * (i % 4)), 32'h0,
            1, 0, 8'(8'h80 + 16 * (i / 4) + 4 * (i % 4)), 32'h0, tag);
    end
    idle();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n === 1'b1) begin
        bit seen [NP];
        seen[0] = 0; seen[1] = 0;
        while (q.size() > 0 && q[0].due == cyc) begin
          item_t it;
          string t;
          it = q.pop_front();
          t  = tq.pop_front();
          seen[it.port] = 1;
          chk(ack[it.port] === 1'b1, {"R9 ack ", t}, 32'(ack[it.port]), 32'h1);
          chk(rdata[it.port*32 +: 32] === it.exp, t, rdata[it.port*32 +: 32], it.exp);
        end
        for (int p = 0; p < NP; p++)
          if (!seen[p]) chk(ack[p] === 1'b0, "R9 no stray ack", 32'(ack[p]), 32'h0);
        chk(irq === model_irq(), "R8 irq level", 32'(irq), 32'(model_irq()));
      end
    end
  end

  initial begin
    #(8 * 60000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) model[i] = 32'h0;
    rst_n = 1'b0; sel = '0; wr = '0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(irq === '0, "R1 irq low", 32'(irq), 32'h0);
    chk(ack === '0, "R1 no ack", 32'(ack), 32'h0);
    read_all("R1 R5 R6 reset contents");

    for (int i = 0; i < NB; i++)
      wr0(8'(8'h80 + 16 * (i / 4) + 4 * (i % 4)), (32'h1 << i) | (32'h0100_0000 * (i + 1)), "R2 set");
    idle();
    read_all("R2 R5 R6 readback");

    wr0(8'h84, 32'h0000_F000, "R4 set keeps zeros");
    wr0(8'hC4, 32'h0000_0000, "R4 clear with zero");
    rd0(8'hC4, "R4 readback");
    wr0(8'hC4, 32'h0000_3000, "R3 partial clear");
    rd0(8'h84, "R3 R6 readback");
    wr0(8'hC4, 32'hFFFF_FFFF, "R8 clear all");
    rd0(8'hC4, "R8 R5 empty");
    idle();

    wr0(8'h00, 32'hFFFF_FFFF, "R7 write low");
    wr0(8'h40, 32'hFFFF_FFFF, "R7 write mid");
    wr0(8'h7C, 32'hFFFF_FFFF, "R7 write edge");
    rd0(8'h00, "R7 read low");
    rd0(8'h7C, "R7 read edge");
    idle();
    read_all("R7 unchanged");

    wr0(8'h83, 32'h8000_0000, "R2 low bits ignored");
    rd0(8'hC0, "R2 low bits readback");
    idle();

    wr0(8'hA8, 32'h0000_00F0, "R10 prep");
    issue(1, 1, 8'hA8, 32'h0000_0110, 1, 1, 8'hE8, 32'h0000_01F0, "R10 set vs clear");
    rd0(8'hE8, "R10 set wins");
    idle();

    issue(1, 1, 8'hBC, 32'h0000_0001, 1, 1, 8'hBC, 32'h0000_0002, "R11 dual set");
    rd0(8'hFC, "R11 dual set readback");
    issue(1, 1, 8'hFC, 32'h0000_0001, 1, 1, 8'hFC, 32'h0000_8000, "R11 dual clear");
    rd0(8'hBC, "R11 dual clear readback");
    idle();

    issue(1, 1, 8'h8C, 32'h00F0_0000, 1, 0, 8'hCC, 32'h0, "R9 read old value");
    issue(1, 1, 8'hCC, 32'hFFFF_FFFF, 1, 0, 8'h8C, 32'h0, "R9 read before clear");
    rd0(8'hCC, "R9 R8 after clear");
    idle();

    for (int i = 0; i < NB; i++)
      wr0(8'(8'hC0 + 16 * (i / 4) + 4 * (i % 4)), 32'hFFFF_FFFF, "R3 R8 clear every box");
    idle();
    read_all("R3 all empty");

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R9 pending responses", 32'(q.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule